// File: doc/BRIEF.md
# Tag-Snooping Reservation Station

This block is a small pool of waiting slots in front of one class of functional unit in an out-of-order core. Each issued operation takes one slot. The slot records the operation code and two source operands. A source is held either as a finished value or as the tag of the station that will produce it. The pool watches the shared result broadcast bus. When a broadcast tag matches a pending source, the slot takes the broadcast value in place of the tag. Once both sources of a slot are values, the slot becomes a candidate for dispatch. The pool offers one candidate per cycle to its functional unit through a valid/ready handshake. When several slots are candidates, the one issued earliest goes first.

After dispatch, a slot stays occupied until its own tag appears on the broadcast bus. Only then can the slot be reused. Each slot has a fixed tag, formed from the unit identifier (upper bits) and the slot index (lower bits). The unit identifier must be non-zero, so no tag ever equals zero. A zero tag always means "the value is present".

Every slot runs its own four-state machine:
- `ST_EMPTY` goes to `ST_WAIT` on *alloc*. This happens when a source still carries a tag after the same-cycle bypass.
- `ST_EMPTY` goes to `ST_READY` on *alloc* when both sources resolve to values.
- `ST_WAIT` goes to `ST_READY` on *last-capture*, when both source tags are zero after this cycle's snoop.
- `ST_READY` goes to `ST_EXEC` on *grant*, when the slot is selected and `dsp_ready` is high.
- `ST_EXEC` goes to `ST_EMPTY` on *own-broadcast*, when a broadcast carries this slot's tag.

A separate age matrix orders the slots by issue time.

Top module: `resv_station`

## Requirements
- R1: An accepted issue stores the op code and both sources. A source given with tag 0 is stored as the value supplied. The stored op code and values appear on `dsp_op`, `dsp_val_a` and `dsp_val_b` when the slot is dispatched.
- R2: Issue is accepted only while a slot is free. With all slots occupied, `iss_ready` is 0 and `full` is 1, and an `iss_valid` pulse has no effect: it takes no slot and is never dispatched.
- R3: A new issue takes the lowest-numbered free slot. `iss_tag` shows that slot's tag, computed as UNIT_ID * 2^IDX_W + index. With the defaults this gives 4..7 for slots 0..3.
- R4: A broadcast (`bc_valid` = 1) whose `bc_tag` equals a pending source tag makes the slot take `bc_val` for that source and clear the tag.
- R5: A slot is offered for dispatch only when both source tags are zero. The earliest offer is in the cycle after the issue or after the broadcast that delivered the last operand.
- R6: If a broadcast matches a source tag in the same cycle as that issue, the broadcast value is captured directly.
- R7: When several slots are ready, the slot issued earliest is offered first.
- R8: A dispatched slot stays occupied until a broadcast carries its own tag. A broadcast of any other tag does not free it.
- R9: A value captured in a slot is not altered by any later broadcast, including a repeat of the same tag.
- R10: The offer holds while `dsp_ready` is 0. A slot is consumed when `dsp_valid` and `dsp_ready` are both 1, and at most one slot is granted per cycle.
- R11: `free_cnt` equals the number of unoccupied slots. It reads 4 after reset with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code to store |
| iss_tag_a | input | TAG_W | Producer tag of source A, 0 when the value is present |
| iss_val_a | input | DATA_W | Value of source A |
| iss_tag_b | input | TAG_W | Producer tag of source B, 0 when the value is present |
| iss_val_b | input | DATA_W | Value of source B |
| iss_ready | output | 1 | A slot is free, so issue is accepted |
| iss_tag | output | TAG_W | Tag of the slot the next issue will take |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| dsp_valid | output | 1 | A ready slot is offered |
| dsp_ready | input | 1 | Functional unit accepts the offer |
| dsp_op | output | OP_W | Op code of the offered slot |
| dsp_val_a | output | DATA_W | Source A value of the offered slot |
| dsp_val_b | output | DATA_W | Source B value of the offered slot |
| dsp_tag | output | TAG_W | Tag of the offered slot |
| free_cnt | output | CNT_W | Number of free slots |
| full | output | 1 | No slot is free |

## Verification
The bench targets the timing edges of this block:
- **Dispatch too early.** A slot whose operand arrives by broadcast must not be offered in the arrival cycle.
- **Lost bypass.** A broadcast coinciding with issue must be captured. A design without the bypass would wait forever on a tag that has already gone by.
- **Age order.** An older slot made ready late must overtake a younger slot that was ready first. A design using plain index priority or ready-time order would dispatch the younger one.
- **Snapshot overwrite and early free.** Repeated or foreign broadcasts must leave captured values and occupied slots alone. A design that got this wrong would corrupt operands or free a slot early.
- **Refused issue when full.** An issue attempted while all slots are occupied must never surface as an extra dispatch.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_WAIT,
        ST_READY,
        ST_EXEC
    } rs_state_e;
endpackage

// File: rtl/rs_entry.sv
`timescale 1ns/1ps
module rs_entry
    import rs_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned OP_W   = 4,
    parameter int unsigned TAG_W  = 4,
    parameter logic [TAG_W-1:0] MY_TAG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [OP_W-1:0]   in_op,
    input  logic [TAG_W-1:0]  in_ta,
    input  logic [DATA_W-1:0] in_va,
    input  logic [TAG_W-1:0]  in_tb,
    input  logic [DATA_W-1:0] in_vb,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    input  logic              grant,
    output logic              is_free,
    output logic              is_ready,
    output logic [OP_W-1:0]   op_o,
    output logic [DATA_W-1:0] va_o,
    output logic [DATA_W-1:0] vb_o
);
    rs_state_e         st_q, st_nx;
    logic [OP_W-1:0]   op_q;
    logic [DATA_W-1:0] va_q, vb_q, va_nx, vb_nx;
    logic [TAG_W-1:0]  qa_q, qb_q, qa_nx, qb_nx;
    logic              own_bc;

    assign own_bc = bc_valid && (bc_tag == MY_TAG);

    // operand capture: at issue (with same-cycle bypass) or by snooping
    always_comb begin
        va_nx = va_q;
        vb_nx = vb_q;
        qa_nx = qa_q;
        qb_nx = qb_q;
        if (st_q == ST_EMPTY && alloc) begin
            if (in_ta == '0) begin
                va_nx = in_va;
                qa_nx = '0;
            end else if (bc_valid && bc_tag == in_ta) begin
                va_nx = bc_val;
                qa_nx = '0;
            end else begin
                va_nx = in_va;
                qa_nx = in_ta;
            end
            if (in_tb == '0) begin
                vb_nx = in_vb;
                qb_nx = '0;
            end else if (bc_valid && bc_tag == in_tb) begin
                vb_nx = bc_val;
                qb_nx = '0;
            end else begin
                vb_nx = in_vb;
                qb_nx = in_tb;
            end
        end else if (st_q == ST_WAIT) begin
            if (qa_q != '0 && bc_valid && bc_tag == qa_q) begin
                va_nx = bc_val;
                qa_nx = '0;
            end
            if (qb_q != '0 && bc_valid && bc_tag == qb_q) begin
                vb_nx = bc_val;
                qb_nx = '0;
            end
        end
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_EMPTY: if (alloc) st_nx = (qa_nx == '0 && qb_nx == '0) ? ST_READY : ST_WAIT;
            ST_WAIT:  if (qa_nx == '0 && qb_nx == '0) st_nx = ST_READY;
            ST_READY: if (grant) st_nx = ST_EXEC;
            ST_EXEC:  if (own_bc) st_nx = ST_EMPTY;
            default:  st_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
            va_q <= '0;
            vb_q <= '0;
            qa_q <= '0;
            qb_q <= '0;
        end else begin
            if (st_q == ST_EMPTY && alloc) op_q <= in_op;
            va_q <= va_nx;
            vb_q <= vb_nx;
            qa_q <= qa_nx;
            qb_q <= qb_nx;
        end
    end

    always_comb begin
        is_free  = (st_q == ST_EMPTY);
        is_ready = (st_q == ST_READY);
        op_o     = op_q;
        va_o     = va_q;
        vb_o     = vb_q;
    end

    // R4
    snoop_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && qa_q != '0 && bc_valid && bc_tag == qa_q)
        |=> (qa_q == '0 && va_q == $past(bc_val)));
    // R5
    dispatch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (st_q == ST_READY && qa_q == '0 && qb_q == '0));
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXEC && !own_bc) |=> (st_q == ST_EXEC));
    // R8
    own_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXEC && own_bc) |=> (st_q == ST_EMPTY));
    // R9
    snapshot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READY && $past(st_q) == ST_READY) |-> ($stable(va_q) && $stable(vb_q)));
endmodule

// File: rtl/rs_age_pick.sv
`timescale 1ns/1ps
module rs_age_pick #(
    parameter int unsigned N_ENT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ENT-1:0] alloc,
    input  logic [N_ENT-1:0] req,
    output logic [N_ENT-1:0] sel
);
    // older_q[i][j] = 1 : slot i was issued before slot j
    logic [N_ENT-1:0] older_q [N_ENT];
    logic [N_ENT-1:0] blocked;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) older_q[i] <= '0;
        end else begin
            for (int k = 0; k < N_ENT; k++) begin
                if (alloc[k]) begin
                    for (int i = 0; i < N_ENT; i++) older_q[i][k] <= (i != k);
                    older_q[k] <= '0;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < N_ENT; j++) begin
                if (req[j] && older_q[j][i]) blocked[i] = 1'b1;
            end
            sel[i] = req[i] && !blocked[i];
        end
    end

    // R10
    single_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    // R7
    pick_when_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (sel != '0));
endmodule

// File: rtl/resv_station.sv
`timescale 1ns/1ps
module resv_station
    import rs_pkg::*;
#(
    parameter int unsigned N_ENT   = 4,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned OP_W    = 4,
    parameter int unsigned UID_W   = 2,
    parameter int unsigned UNIT_ID = 1,
    localparam int unsigned IDX_W  = $clog2(N_ENT),
    localparam int unsigned TAG_W  = UID_W + IDX_W,
    localparam int unsigned CNT_W  = $clog2(N_ENT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_tag_a,
    input  logic [DATA_W-1:0] iss_val_a,
    input  logic [TAG_W-1:0]  iss_tag_b,
    input  logic [DATA_W-1:0] iss_val_b,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              dsp_valid,
    input  logic              dsp_ready,
    output logic [OP_W-1:0]   dsp_op,
    output logic [DATA_W-1:0] dsp_val_a,
    output logic [DATA_W-1:0] dsp_val_b,
    output logic [TAG_W-1:0]  dsp_tag,
    output logic [CNT_W-1:0]  free_cnt,
    output logic              full
);
    logic [N_ENT-1:0]  free_v, ready_v, alloc_v, sel_v, grant_v;
    logic [OP_W-1:0]   ent_op [N_ENT];
    logic [DATA_W-1:0] ent_va [N_ENT];
    logic [DATA_W-1:0] ent_vb [N_ENT];
    logic [IDX_W-1:0]  pick_idx, sel_idx;
    logic              pick_ok;

    // lowest free slot
    always_comb begin
        pick_idx = '0;
        pick_ok  = 1'b0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (free_v[i]) begin
                pick_idx = IDX_W'(i);
                pick_ok  = 1'b1;
            end
        end
    end

    assign alloc_v   = (iss_valid && pick_ok) ? (N_ENT'(1) << pick_idx) : '0;
    assign iss_ready = pick_ok;
    assign full      = !pick_ok;
    assign iss_tag   = {UID_W'(UNIT_ID), pick_idx};
    assign grant_v   = sel_v & {N_ENT{dsp_ready}};

    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < N_ENT; i++) free_cnt = free_cnt + CNT_W'(free_v[i]);
    end

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_ent
            localparam logic [TAG_W-1:0] ETAG = {UID_W'(UNIT_ID), IDX_W'(g)};
            rs_entry #(
                .DATA_W (DATA_W),
                .OP_W   (OP_W),
                .TAG_W  (TAG_W),
                .MY_TAG (ETAG)
            ) u_ent (
                .clk      (clk),
                .rst_n    (rst_n),
                .alloc    (alloc_v[g]),
                .in_op    (iss_op),
                .in_ta    (iss_tag_a),
                .in_va    (iss_val_a),
                .in_tb    (iss_tag_b),
                .in_vb    (iss_val_b),
                .bc_valid (bc_valid),
                .bc_tag   (bc_tag),
                .bc_val   (bc_val),
                .grant    (grant_v[g]),
                .is_free  (free_v[g]),
                .is_ready (ready_v[g]),
                .op_o     (ent_op[g]),
                .va_o     (ent_va[g]),
                .vb_o     (ent_vb[g])
            );
        end
    endgenerate

    rs_age_pick #(
        .N_ENT (N_ENT)
    ) u_age (
        .clk   (clk),
        .rst_n (rst_n),
        .alloc (alloc_v),
        .req   (ready_v),
        .sel   (sel_v)
    );

    // dispatch mux
    always_comb begin
        dsp_op    = '0;
        dsp_val_a = '0;
        dsp_val_b = '0;
        sel_idx   = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (sel_v[i]) begin
                dsp_op    = ent_op[i];
                dsp_val_a = ent_va[i];
                dsp_val_b = ent_vb[i];
                sel_idx   = IDX_W'(i);
            end
        end
        dsp_valid = |sel_v;
        dsp_tag   = {UID_W'(UNIT_ID), sel_idx};
    end

    // R11
    alloc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && !bc_valid) |=> (free_cnt == $past(free_cnt) - 1'b1));
    // R2
    full_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !bc_valid) |=> (full && free_cnt == '0));
endmodule

// File: tb/resv_station_tb.sv
`timescale 1ns/1ps
module resv_station_tb;
    localparam int TAG0 = 4;

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] va;
        logic [15:0] vb;
        logic [3:0]  tag;
    } disp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_op = '0;
    logic [3:0]  iss_tag_a = '0;
    logic [15:0] iss_val_a = '0;
    logic [3:0]  iss_tag_b = '0;
    logic [15:0] iss_val_b = '0;
    logic        iss_ready;
    logic [3:0]  iss_tag;
    logic        bc_valid = 1'b0;
    logic [3:0]  bc_tag = '0;
    logic [15:0] bc_val = '0;
    logic        dsp_valid;
    logic        dsp_ready = 1'b1;
    logic [3:0]  dsp_op;
    logic [15:0] dsp_val_a, dsp_val_b;
    logic [3:0]  dsp_tag;
    logic [2:0]  free_cnt;
    logic        full;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    bit    busy_m [4];
    disp_t exp_q [$];

    always #2 clk = ~clk;

    resv_station u_dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_tag_a(iss_tag_a), .iss_val_a(iss_val_a),
        .iss_tag_b(iss_tag_b), .iss_val_b(iss_val_b),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_op(dsp_op),
        .dsp_val_a(dsp_val_a), .dsp_val_b(dsp_val_b), .dsp_tag(dsp_tag),
        .free_cnt(free_cnt), .full(full)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // monitor: compares every consumed dispatch with the scoreboard
    always @(negedge clk) begin
        if (rst_n && dsp_valid && dsp_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected dispatch op", int'(dsp_op), -1);
            end else begin
                disp_t e;
                e = exp_q.pop_front();
                chk(dsp_op == e.op, "R1 op", int'(dsp_op), int'(e.op));
                chk(dsp_val_a == e.va, "R1 val_a", int'(dsp_val_a), int'(e.va));
                chk(dsp_val_b == e.vb, "R1 val_b", int'(dsp_val_b), int'(e.vb));
                chk(dsp_tag == e.tag, "R7 order/tag", int'(dsp_tag), int'(e.tag));
            end
        end
    end

    task automatic push(input int op, input int va, input int vb, input int tag);
        disp_t e;
        e.op = 4'(op); e.va = 16'(va); e.vb = 16'(vb); e.tag = 4'(tag);
        exp_q.push_back(e);
    endtask

    task automatic do_issue(input int op, input int ta, input int va, input int tb,
                            input int vb, output int idx);
        idx = -1;
        for (int i = 3; i >= 0; i--) if (!busy_m[i]) idx = i;
        iss_valid = 1'b1; iss_op = 4'(op);
        iss_tag_a = 4'(ta); iss_val_a = 16'(va);
        iss_tag_b = 4'(tb); iss_val_b = 16'(vb);
        #1;
        chk(iss_ready == 1'b1, "R2 ready", int'(iss_ready), 1);
        chk(int'(iss_tag) == TAG0 + idx, "R3 slot tag", int'(iss_tag), TAG0 + idx);
        @(posedge clk); #1;
        iss_valid = 1'b0;
        bc_valid = 1'b0;
        busy_m[idx] = 1;
    endtask

    task automatic bcast(input int tag, input int val);
        bc_valid = 1'b1; bc_tag = 4'(tag); bc_val = 16'(val);
        @(posedge clk); #1;
        bc_valid = 1'b0;
    endtask

    task automatic retire(input int idx);
        repeat (2) @(posedge clk);
        #1;
        bcast(TAG0 + idx, 0);
        busy_m[idx] = 0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            chk(0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        int idx;
        for (int i = 0; i < 4; i++) busy_m[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // reset state: R11, R3
        chk(dsp_valid == 1'b0, "R10 reset dsp_valid", int'(dsp_valid), 0);
        chk(free_cnt == 3'd4, "R11 reset free_cnt", int'(free_cnt), 4);
        chk(full == 1'b0, "R2 reset full", int'(full), 0);
        chk(iss_tag == 4'(TAG0), "R3 reset tag", int'(iss_tag), TAG0);
        @(posedge clk); #1;

        // S1: both sources ready at issue (R1, R5, R8)
        push(1, 10, 20, TAG0);
        do_issue(1, 0, 10, 0, 20, idx);
        @(negedge clk);
        chk(dsp_valid == 1'b1, "R5 offer after issue", int'(dsp_valid), 1);
        @(negedge clk);
        chk(free_cnt == 3'd3, "R8 busy after dispatch", int'(free_cnt), 3);
        bcast(TAG0 + 1, 0);
        @(negedge clk);
        chk(free_cnt == 3'd3, "R8 foreign tag keeps slot", int'(free_cnt), 3);
        retire(0);
        @(negedge clk);
        chk(free_cnt == 3'd4, "R8 own tag frees", int'(free_cnt), 4);

        // S2: wait on tag 9 (R4, R5)
        push(2, 77, 5, TAG0);
        do_issue(2, 9, 0, 0, 5, idx);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(dsp_valid == 1'b0, "R5 blocked on tag", int'(dsp_valid), 0);
        end
        bcast(9, 77);
        @(negedge clk);
        chk(dsp_valid == 1'b1, "R5 offer after capture", int'(dsp_valid), 1);
        chk(dsp_val_a == 16'd77, "R4 captured value", int'(dsp_val_a), 77);
        retire(0);

        // S3: snapshot kept, offer held (R9, R10)
        @(posedge clk); #1;
        dsp_ready = 1'b0;
        do_issue(3, 0, 30, 10, 0, idx);
        bcast(10, 40);
        bcast(10, 41);
        bcast(9, 999);
        @(negedge clk);
        chk(dsp_valid == 1'b1, "R10 offer held", int'(dsp_valid), 1);
        chk(dsp_val_a == 16'd30, "R9 val_a kept", int'(dsp_val_a), 30);
        chk(dsp_val_b == 16'd40, "R9 val_b kept", int'(dsp_val_b), 40);
        push(3, 30, 40, TAG0);
        @(posedge clk); #1;
        dsp_ready = 1'b1;
        retire(0);

        // S4: same-cycle bypass (R6)
        push(4, 55, 6, TAG0);
        bc_valid = 1'b1; bc_tag = 4'd11; bc_val = 16'd55;
        do_issue(4, 11, 0, 0, 6, idx);
        @(negedge clk);
        chk(dsp_valid == 1'b1, "R6 bypass ready", int'(dsp_valid), 1);
        chk(dsp_val_a == 16'd55, "R6 bypass value", int'(dsp_val_a), 55);
        retire(0);

        // S5: older slot ready late still goes first (R7)
        @(posedge clk); #1;
        dsp_ready = 1'b0;
        do_issue(5, 12, 0, 0, 1, idx);
        do_issue(6, 0, 2, 0, 3, idx);
        @(negedge clk);
        chk(int'(dsp_tag) == TAG0 + 1, "R7 only young ready", int'(dsp_tag), TAG0 + 1);
        bcast(12, 88);
        @(negedge clk);
        chk(int'(dsp_tag) == TAG0, "R7 oldest first", int'(dsp_tag), TAG0);
        push(5, 88, 1, TAG0);
        push(6, 2, 3, TAG0 + 1);
        @(posedge clk); #1;
        dsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(dsp_valid == 1'b0, "R10 drained", int'(dsp_valid), 0);
        retire(0);
        retire(1);

        // S6: full pool and refused issue (R2, R11)
        for (int k = 0; k < 4; k++) do_issue(7 + k, 13, 0, 0, 100 + k, idx);
        @(negedge clk);
        chk(full == 1'b1, "R2 full", int'(full), 1);
        chk(iss_ready == 1'b0, "R2 not ready", int'(iss_ready), 0);
        chk(free_cnt == 3'd0, "R11 zero free", int'(free_cnt), 0);
        @(posedge clk); #1;
        iss_valid = 1'b1; iss_op = 4'd15;
        iss_tag_a = '0; iss_val_a = 16'd1; iss_tag_b = '0; iss_val_b = 16'd1;
        @(posedge clk); #1;
        iss_valid = 1'b0;
        @(negedge clk);
        chk(free_cnt == 3'd0, "R2 refused issue", int'(free_cnt), 0);
        chk(dsp_valid == 1'b0, "R2 refused not offered", int'(dsp_valid), 0);
        for (int k = 0; k < 4; k++) push(7 + k, 200, 100 + k, TAG0 + k);
        @(posedge clk); #1;
        bcast(13, 200);
        repeat (6) @(negedge clk);
        chk(dsp_valid == 1'b0, "R2 nothing extra", int'(dsp_valid), 0);
        chk(exp_q.size() == 0, "R7 all dispatched", exp_q.size(), 0);
        for (int k = 0; k < 4; k++) retire(k);
        @(negedge clk);
        chk(free_cnt == 3'd4, "R11 all free", int'(free_cnt), 4);

        if (!done) begin
            done = 1;
            finish_run();
        end
    end
endmodule